// File: doc/BRIEF.md
# Firmware Image Streaming Loader

This block takes a firmware image as a byte stream and copies it into the program RAM of an embedded processor. The image is a run of chunks with no gaps between them. Each chunk starts with a four-byte header: a 16-bit little-endian target address, then a 16-bit little-endian byte count. The payload bytes follow the header. For every chunk that has a payload, the loader first sets the RAM address pointer with two writes, one for the high byte and one for the low byte. It then sends each payload byte through a data port, and the address advances by one after every data write.

A pulse on `startLoad` begins a load. If the processor already reports that it is running, nothing is loaded and the block finishes at once. Otherwise the loader raises the processor reset request and waits for the processor to confirm that it is in reset. Only then does it accept the stream. After the final byte of the image, the loader drops the reset request and waits for the confirmation to clear.

Each of the two waits is bounded by a cycle count set by a parameter. If a wait runs out, the timeout error is set. If the stream ends in the middle of a header or a payload, the truncation error is set and the processor is left in reset.

Top module: `fw_stream_loader`

## Requirements
- R1: Header bytes are taken in this order: address bits [7:0], address bits [15:8], length bits [7:0], length bits [15:8]. The payload bytes that follow are written in arrival order.
- R2: A chunk with a non-zero length produces three kinds of write, in this order. First, one write with `ramSel`=0 carrying address bits [15:8]. In the next cycle, one write with `ramSel`=1 carrying address bits [7:0]. Then one write with `ramSel`=2 for each payload byte. `ramAddr` shows the chunk address on the two address writes. On data writes it starts at the chunk address and increases by one per byte, wrapping at 16 bits.
- R3: Chunks follow each other directly. The byte after a chunk's last payload byte is the first header byte of the next chunk.
- R4: A chunk with length zero causes no write of any kind. Parsing continues with the next header. A zero-length chunk may also be the last chunk of the image.
- R5: After a start (processor not running), `procResetReq` rises in the next cycle. `inReady` stays low until `procInReset` has been seen high. `inReady` is only ever high while `procResetReq` is high.
- R6: When a byte flagged `inLast` completes the final chunk, `procResetReq` falls in the next cycle. `loadDone` rises once `procInReset` is seen low.
- R7: If `procRunning` is high when `startLoad` is seen, the load is skipped. In the next cycle `loadDone` and `loadSkipped` are both high and `procResetReq` is low. No stream byte is accepted and no write occurs.
- R8: A wait for `procInReset` to rise, or to fall, that lasts `TIMEOUT_CYCLES` cycles ends the load with `errTimeout` set. A timeout in the first wait keeps `procResetReq` high.
- R9: If `inLast` comes with a byte that does not complete a chunk, or with a header byte that announces a non-zero length, `errTruncated` is set and `procResetReq` stays high. No further byte is accepted.
- R10: At most one of `loadDone`, `errTruncated` and `errTimeout` is high at a time. All of these flags clear when a new start is seen. A RAM write is only issued in the cycle after one in which `procResetReq` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Begin a load (sampled when idle) |
| procRunning | input | 1 | Processor reports it is running |
| procInReset | input | 1 | Processor reports reset is in effect |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Marks the final byte of the stream |
| inReady | output | 1 | Loader accepts a stream byte |
| ramWe | output | 1 | RAM port write strobe |
| ramSel | output | 2 | Target: 0 address high, 1 address low, 2 data |
| ramByte | output | 8 | Byte written |
| ramAddr | output | 16 | Address the write belongs to |
| procResetReq | output | 1 | Hold the processor in reset |
| busy | output | 1 | Load in progress |
| loadDone | output | 1 | Last load finished normally (or was skipped) |
| loadSkipped | output | 1 | Last load was skipped because the processor was running |
| errTruncated | output | 1 | Last load hit an early end of stream |
| errTimeout | output | 1 | Last load timed out on a reset wait |

## Verification
The first image has several chunks: a payload chunk, then a zero-length chunk, then a chunk whose address crosses a low-byte boundary. It is sent with idle cycles between bytes. This separates correct header byte order and address carry from stalls that are mishandled. A second image ends on a zero-length chunk, and a third starts at 0xFFFE. These show that the end of the image and the 16-bit address wrap are found from the length alone. Streams cut off inside a header and inside a payload, runs with the processor stuck in or out of reset, and a start while the processor is running separate the truncation, timeout and skip outcomes from one another and from a normal completion.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int HDR_BYTES = 4;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_DATA    = 2'd2
  } ramSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SET,
    ST_HDR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_PAYLOAD,
    ST_WAIT_CLR
  } ldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             hdrLoad;
    logic [IDX_W-1:0] hdrIdx;
    logic             wrAddrHi;
    logic             wrAddrLo;
    logic             wrData;
    logic             timerClr;
  } ctrlStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic lenZeroNext;
    logic remainOne;
    logic timerDone;
  } dpStatus_t;
endpackage

// File: rtl/fwl_datapath.sv
module fwl_datapath
  import fwl_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 150_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] inData,
  output dpStatus_t         status,
  output logic              ramWe,
  output logic [1:0]        ramSel,
  output logic [BYTE_W-1:0] ramByte,
  output logic [ADDR_W-1:0] ramAddr
);
  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  logic [(HDR_BYTES-1)*BYTE_W-1:0] hdrVec;
  logic [ADDR_W-1:0]  ptr;
  logic [ADDR_W-1:0]  remain;
  logic [TIMER_W-1:0] timer;

  // first header bytes held until the final one arrives (R1)
  for (genvar gi = 0; gi < HDR_BYTES - 1; gi++) begin : g_hdr
    logic [BYTE_W-1:0] hb;
    always_ff @(posedge clk) begin
      if (!rstN) hb <= '0;
      else if (strobe.hdrLoad && strobe.hdrIdx == IDX_W'(gi)) hb <= inData;
    end
    assign hdrVec[gi*BYTE_W +: BYTE_W] = hb;
  end

  logic [BYTE_W-1:0] addrLoB, addrHiB, lenLoB;
  assign addrLoB = hdrVec[0*BYTE_W +: BYTE_W];
  assign addrHiB = hdrVec[1*BYTE_W +: BYTE_W];
  assign lenLoB  = hdrVec[2*BYTE_W +: BYTE_W];

  // address pointer with auto-increment and remaining byte count (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      remain <= '0;
    end else if (strobe.hdrLoad && strobe.hdrIdx == LAST_IDX) begin
      ptr    <= {addrHiB, addrLoB};
      remain <= {inData, lenLoB};
    end else if (strobe.wrData) begin
      ptr    <= ptr + 1'b1;
      remain <= remain - 1'b1;
    end
  end

  // registered RAM port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramSel  <= '0;
      ramByte <= '0;
      ramAddr <= '0;
    end else begin
      ramWe <= strobe.wrAddrHi | strobe.wrAddrLo | strobe.wrData;
      if (strobe.wrAddrHi) begin
        ramSel  <= SEL_ADDR_HI;
        ramByte <= ptr[ADDR_W-1 -: BYTE_W];
        ramAddr <= ptr;
      end else if (strobe.wrAddrLo) begin
        ramSel  <= SEL_ADDR_LO;
        ramByte <= ptr[BYTE_W-1:0];
        ramAddr <= ptr;
      end else if (strobe.wrData) begin
        ramSel  <= SEL_DATA;
        ramByte <= inData;
        ramAddr <= ptr;
      end
    end
  end

  // shared wait timer (R8)
  always_ff @(posedge clk) begin
    if (!rstN)                timer <= '0;
    else if (strobe.timerClr) timer <= '0;
    else                      timer <= timer + 1'b1;
  end

  assign status.lenZeroNext = (inData == '0) && (lenLoB == '0);
  assign status.remainOne   = (remain == ADDR_W'(1));
  assign status.timerDone   = (timer == TIMER_LAST);
endmodule

// File: rtl/fwl_ctrl.sv
module fwl_ctrl
  import fwl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startLoad,
  input  logic        procRunning,
  input  logic        procInReset,
  input  logic        inValid,
  input  logic        inLast,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        inReady,
  output logic        procResetReq,
  output logic        busy,
  output logic        loadDone,
  output logic        loadSkipped,
  output logic        errTruncated,
  output logic        errTimeout
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  ldState_e         st, stNext;
  logic [IDX_W-1:0] hdrCnt, cntNext;
  logic             reqNext, doneNext, skipNext, truncNext, toutNext;

  always_comb begin
    stNext    = st;
    cntNext   = hdrCnt;
    reqNext   = procResetReq;
    doneNext  = loadDone;
    skipNext  = loadSkipped;
    truncNext = errTruncated;
    toutNext  = errTimeout;
    strobe        = '0;
    strobe.hdrIdx = hdrCnt;
    inReady       = 1'b0;
    case (st)
      ST_IDLE: begin
        if (startLoad) begin
          doneNext  = 1'b0;
          skipNext  = 1'b0;
          truncNext = 1'b0;
          toutNext  = 1'b0;
          strobe.timerClr = 1'b1;
          if (procRunning) begin          // R7 skip
            reqNext  = 1'b0;
            doneNext = 1'b1;
            skipNext = 1'b1;
          end else begin                  // R5 enter reset
            reqNext = 1'b1;
            stNext  = ST_WAIT_SET;
          end
        end
      end
      ST_WAIT_SET: begin
        if (procInReset) begin
          stNext  = ST_HDR;
          cntNext = '0;
        end else if (status.timerDone) begin
          toutNext = 1'b1;                // R8
          stNext   = ST_IDLE;
        end
      end
      ST_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.hdrLoad = 1'b1;
          if (hdrCnt == LAST_IDX) begin
            cntNext = '0;
            if (status.lenZeroNext) begin  // R4
              if (inLast) begin
                reqNext = 1'b0;
                strobe.timerClr = 1'b1;
                stNext = ST_WAIT_CLR;
              end
            end else if (inLast) begin     // R9
              truncNext = 1'b1;
              stNext    = ST_IDLE;
            end else begin
              stNext = ST_ADDR_HI;
            end
          end else if (inLast) begin       // R9
            truncNext = 1'b1;
            stNext    = ST_IDLE;
          end else begin
            cntNext = hdrCnt + 1'b1;
          end
        end
      end
      ST_ADDR_HI: begin
        strobe.wrAddrHi = 1'b1;
        stNext = ST_ADDR_LO;
      end
      ST_ADDR_LO: begin
        strobe.wrAddrLo = 1'b1;
        stNext = ST_PAYLOAD;
      end
      ST_PAYLOAD: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.wrData = 1'b1;
          if (status.remainOne) begin
            if (inLast) begin              // R6 release
              reqNext = 1'b0;
              strobe.timerClr = 1'b1;
              stNext = ST_WAIT_CLR;
            end else begin                 // R3 next header
              stNext = ST_HDR;
            end
          end else if (inLast) begin
            truncNext = 1'b1;
            stNext    = ST_IDLE;
          end
        end
      end
      ST_WAIT_CLR: begin
        if (!procInReset) begin
          doneNext = 1'b1;
          stNext   = ST_IDLE;
        end else if (status.timerDone) begin
          toutNext = 1'b1;
          stNext   = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st           <= ST_IDLE;
      hdrCnt       <= '0;
      procResetReq <= 1'b0;
      loadDone     <= 1'b0;
      loadSkipped  <= 1'b0;
      errTruncated <= 1'b0;
      errTimeout   <= 1'b0;
    end else begin
      st           <= stNext;
      hdrCnt       <= cntNext;
      procResetReq <= reqNext;
      loadDone     <= doneNext;
      loadSkipped  <= skipNext;
      errTruncated <= truncNext;
      errTimeout   <= toutNext;
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/fw_stream_loader.sv
module fw_stream_loader
  import fwl_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 150_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startLoad,
  input  logic              procRunning,
  input  logic              procInReset,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              ramWe,
  output logic [1:0]        ramSel,
  output logic [BYTE_W-1:0] ramByte,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              procResetReq,
  output logic              busy,
  output logic              loadDone,
  output logic              loadSkipped,
  output logic              errTruncated,
  output logic              errTimeout
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  fwl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .procRunning(procRunning),
    .procInReset(procInReset), .inValid(inValid), .inLast(inLast),
    .status(status), .strobe(strobe), .inReady(inReady),
    .procResetReq(procResetReq), .busy(busy), .loadDone(loadDone),
    .loadSkipped(loadSkipped), .errTruncated(errTruncated), .errTimeout(errTimeout)
  );

  fwl_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .status(status),
    .ramWe(ramWe), .ramSel(ramSel), .ramByte(ramByte), .ramAddr(ramAddr)
  );
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker
  import fwl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              ramWe,
  input logic [1:0]        ramSel,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              procResetReq,
  input logic              busy,
  input logic              loadDone,
  input logic              loadSkipped,
  input logic              errTruncated,
  input logic              errTimeout
);
  a_r5_ready_under_reset: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (procResetReq && busy));

  a_r10_write_after_reset_req: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(procResetReq));

  a_r2_lo_follows_hi: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramSel == SEL_ADDR_HI) |=> (ramWe && ramSel == SEL_ADDR_LO));

  a_r2_addr_increments: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramSel == SEL_DATA && $past(ramWe && ramSel == SEL_DATA))
      |-> (ramAddr == ADDR_W'($past(ramAddr) + 1'b1)));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadDone, errTruncated, errTimeout}));

  a_r9_trunc_keeps_reset: assert property (@(posedge clk) disable iff (!rstN)
    errTruncated |-> procResetReq);

  a_r7_skip_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    loadSkipped |-> (loadDone && !procResetReq));
endmodule

bind fw_stream_loader fwl_checker u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .ramWe(ramWe), .ramSel(ramSel),
  .ramAddr(ramAddr), .procResetReq(procResetReq), .busy(busy),
  .loadDone(loadDone), .loadSkipped(loadSkipped),
  .errTruncated(errTruncated), .errTimeout(errTimeout)
);

// File: tb/sim_fw_stream_loader.sv
module sim_fw_stream_loader;
  localparam int TO = 32;

  logic clk = 1'b0, rstN = 1'b0, startLoad = 1'b0, procRunning = 1'b0;
  logic procInReset = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, ramWe, procResetReq, busy, loadDone, loadSkipped, errTruncated, errTimeout;
  logic [1:0] ramSel;
  logic [7:0] ramByte;
  logic [15:0] ramAddr;

  always #10 clk = ~clk;

  fw_stream_loader #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .procRunning(procRunning),
    .procInReset(procInReset), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .ramWe(ramWe), .ramSel(ramSel), .ramByte(ramByte),
    .ramAddr(ramAddr), .procResetReq(procResetReq), .busy(busy),
    .loadDone(loadDone), .loadSkipped(loadSkipped),
    .errTruncated(errTruncated), .errTimeout(errTimeout)
  );

  typedef struct packed { logic [1:0] sel; logic [7:0] b; logic [15:0] a; } wr_t;
  wr_t expQ[$];
  logic [7:0] streamQ[$];
  int nChecks = 0, nFails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // processor model: reset status follows the request three cycles later
  bit stuckMode = 1'b0, stuckVal = 1'b0;
  logic [2:0] pipe = 3'b000;
  initial forever begin
    @(negedge clk);
    pipe = {pipe[1:0], procResetReq};
    procInReset = stuckMode ? stuckVal : pipe[2];
  end

  // write monitor compared every clock against the expected write list
  initial forever begin
    @(negedge clk);
    if (rstN && ramWe) begin
      if (expQ.size() == 0) check("R1/R2 unexpected write", {6'b0, ramSel, ramByte, ramAddr}, 32'hFFFF_FFFF);
      else begin
        wr_t e;
        e = expQ.pop_front();
        check("R1/R2 write", {6'b0, ramSel, ramByte, ramAddr}, {6'b0, e});
      end
    end
  end

  task automatic addChunk(input logic [15:0] addr, input int len, input logic [7:0] seed);
    streamQ.push_back(addr[7:0]);
    streamQ.push_back(addr[15:8]);
    streamQ.push_back(8'(len));
    streamQ.push_back(8'(len >> 8));
    if (len > 0) begin
      expQ.push_back({2'd0, addr[15:8], addr});
      expQ.push_back({2'd1, addr[7:0], addr});
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      streamQ.push_back(b);
      expQ.push_back({2'd2, b, 16'(addr + 16'(i))});
    end
  endtask

  task automatic sendStream(input bit gaps);
    int n;
    n = streamQ.size();
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = streamQ[i];
      inLast  = (i == n - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    streamQ.delete();
  endtask

  task automatic pulseStart();
    startLoad = 1'b1;
    @(negedge clk);
    startLoad = 1'b0;
  endtask

  task automatic waitEnd();
    for (int k = 0; k < 400; k++) begin
      if (loadDone || errTruncated || errTimeout) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset inReady", inReady, 0);
    check("R5 reset procResetReq", procResetReq, 0);
    check("R10 reset busy", busy, 0);
    check("R10 reset ramWe", ramWe, 0);
    check("R10 reset loadDone", loadDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    // A: payload chunk, zero-length chunk, chunk crossing a low-byte boundary
    addChunk(16'h1234, 3, 8'hA0);
    addChunk(16'h5555, 0, 8'h00);
    addChunk(16'h00FF, 2, 8'h31);
    pulseStart();
    check("R5 request raised", procResetReq, 1);
    check("R5 not ready before status", inReady, 0);
    sendStream(1'b1);
    check("R6 request released", procResetReq, 0);
    waitEnd();
    check("R6 loadDone", loadDone, 1);
    check("R6 no truncation", errTruncated, 0);
    check("R6 no timeout", errTimeout, 0);
    check("R3/R4 all writes seen", expQ.size(), 0);

    // B: image ends on a zero-length chunk
    addChunk(16'hBEEF, 1, 8'h77);
    addChunk(16'h4000, 0, 8'h00);
    pulseStart();
    sendStream(1'b0);
    waitEnd();
    check("R4 end on empty chunk done", loadDone, 1);
    check("R4 writes", expQ.size(), 0);

    // C: processor already running
    procRunning = 1'b1;
    pulseStart();
    check("R7 done", loadDone, 1);
    check("R7 skipped", loadSkipped, 1);
    check("R7 no reset", procResetReq, 0);
    repeat (5) @(negedge clk);
    check("R7 no stream accepted", inReady, 0);
    check("R7 still idle", busy, 0);
    procRunning = 1'b0;

    // D: stream ends inside a header
    streamQ.push_back(8'h10);
    streamQ.push_back(8'h20);
    pulseStart();
    sendStream(1'b0);
    waitEnd();
    check("R9 header truncation", errTruncated, 1);
    check("R9 reset held", procResetReq, 1);
    check("R9 no done", loadDone, 0);
    check("R9 not ready", inReady, 0);

    // E: stream ends inside a payload
    streamQ.push_back(8'h00); streamQ.push_back(8'h08);
    streamQ.push_back(8'h04); streamQ.push_back(8'h00);
    streamQ.push_back(8'h61); streamQ.push_back(8'h62);
    expQ.push_back({2'd0, 8'h08, 16'h0800});
    expQ.push_back({2'd1, 8'h00, 16'h0800});
    expQ.push_back({2'd2, 8'h61, 16'h0800});
    expQ.push_back({2'd2, 8'h62, 16'h0801});
    pulseStart();
    sendStream(1'b0);
    waitEnd();
    @(negedge clk);
    check("R9 payload truncation", errTruncated, 1);
    check("R9 reset held after payload cut", procResetReq, 1);
    check("R9 partial writes", expQ.size(), 0);

    // F: reset never confirmed
    stuckMode = 1'b1; stuckVal = 1'b0;
    pulseStart();
    repeat (TO - 2) @(negedge clk);
    check("R8 no early timeout", errTimeout, 0);
    repeat (4) @(negedge clk);
    check("R8 set-wait timeout", errTimeout, 1);
    check("R8 reset still requested", procResetReq, 1);
    check("R8 no stream", inReady, 0);

    // G: reset never clears
    stuckVal = 1'b1;
    addChunk(16'h0100, 1, 8'h5A);
    pulseStart();
    check("R10 flags cleared on start", errTimeout, 0);
    sendStream(1'b0);
    waitEnd();
    check("R8 clear-wait timeout", errTimeout, 1);
    check("R8 no done", loadDone, 0);
    check("R8 request dropped", procResetReq, 0);

    // H: recovery, address wraps at 16 bits
    stuckMode = 1'b0;
    addChunk(16'hFFFE, 3, 8'h01);
    pulseStart();
    sendStream(1'b1);
    waitEnd();
    check("R10 recovered done", loadDone, 1);
    check("R10 timeout flag cleared", errTimeout, 0);
    check("R2 wrap writes", expQ.size(), 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule